// File: doc/BRIEF.md
# 64-bit Byte Manipulation Unit

This execution unit carries out byte-granular operations on 64-bit operands for an integer pipeline. It covers four kinds of work. It can clear, pull out or place a byte, word, longword or quadword field at a byte offset. It can zero selected bytes under an 8-bit enable mask. It can shift a value left, right logically or right arithmetically. It can compare all eight bytes of two operands at once, as unsigned values, and return a bit mask.

The unit receives the operand A value, the register value for operand B, and the slice of the instruction word that carries the function code, the literal flag and the 8-bit literal. The bit numbering of that slice is kept as it is in the instruction word. The result is computed combinationally and captured in an output register. It appears one clock edge after a request is presented with `in_valid` high. A function code the unit does not implement raises an illegal-operation flag and returns zero.

Top module: `bmu_top`

## Requirements
- R1: When `insn[12]` is 1, operand B is the literal `insn[20:13]`, zero-extended to 64 bits. When `insn[12]` is 0, operand B is `b_val`.
- R2: The mask-low codes (function `insn[11:5]` = 0x02, 0x12, 0x22, 0x32 for 1, 2, 4, 8 bytes) return A with that many bytes cleared, starting at byte offset B[2:0]. Bytes of the field beyond byte 7 are ignored.
- R3: The extract-low codes (0x06, 0x16, 0x26, 0x36 for 1, 2, 4, 8 bytes) return the field of A that starts at byte offset B[2:0], right-aligned, with zeros above it. Bytes past byte 7 of A read as zero.
- R4: The insert-low codes (0x0B, 0x1B, 0x2B, 0x3B for 1, 2, 4, 8 bytes) place the low bytes of A at byte offset B[2:0] in an otherwise zero result. Bytes that would land above byte 7 are dropped.
- R5: Code 0x30 zeroes byte i of A wherever B bit i is 1. Code 0x31 zeroes byte i wherever B bit i is 0.
- R6: Code 0x34 shifts A right with zero fill, and code 0x39 shifts A left, keeping the low 64 bits. The shift amount is B[5:0] only; B bits 63:6 have no effect.
- R7: Code 0x3C shifts A right by B[5:0], filling with copies of A bit 63.
- R8: Code 0x0F sets result bit i (i = 0..7) when unsigned byte i of A is greater than or equal to byte i of B. Result bits 63:8 are zero.
- R9: Any other function code sets `illegal` to 1 and `result` to zero. Every implemented code leaves `illegal` at 0.
- R10: `result`, `illegal` and `out_valid` update on the clock edge where `in_valid` is 1, and `out_valid` is 1 for exactly the cycle after each such edge. While `in_valid` is 0, `result` and `illegal` hold their values. A synchronous reset clears all three outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| insn | input | 16 (bits 20:5) | Instruction slice: literal 20:13, literal flag 12, function 11:5 |
| a_val | input | 64 | Operand A |
| b_val | input | 64 | Operand B register value |
| out_valid | output | 1 | Result captured from a request on the previous edge |
| result | output | 64 | Registered result |
| illegal | output | 1 | Registered unsupported-function flag |

## Verification
The hardest cases to reach are the field operations where the field runs past byte 7. Examples are a quadword insert or mask at a non-zero offset, and a longword extract at offset 6. In these cases the dropped bytes must not wrap around or leak into the result. The stimulus sweeps every size against offsets 0, 3, 5 and 7, using A values whose bytes are all distinct, so that any misplaced or wrapped byte shows as a mismatch. The shift tests set the high bits of B so that a shift amount wider than six bits would give a different answer. The literal tests put a conflicting value on `b_val`, so a wrong operand choice is also visible.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    localparam int LANES = 8;
    localparam int DW    = LANES * 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_QUAD = 2'd3
    } size_e;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_MSK,
        OP_EXT,
        OP_INS,
        OP_ZAP,
        OP_ZAPNOT,
        OP_SRL,
        OP_SLL,
        OP_SRA,
        OP_CMPGE
    } op_e;

    typedef struct packed {
        op_e   op;
        size_e size;
        logic  bad;
    } dec_t;

    // Field-size bits sit at function bits 5:4; the low nibble selects the kind.
    function automatic dec_t decode(input logic [6:0] f);
        dec_t d;
        d.op   = OP_NONE;
        d.size = size_e'(f[5:4]);
        d.bad  = 1'b0;
        casez (f)
            7'b00??_0010: d.op = OP_MSK;
            7'b00??_0110: d.op = OP_EXT;
            7'b00??_1011: d.op = OP_INS;
            7'h30:        d.op = OP_ZAP;
            7'h31:        d.op = OP_ZAPNOT;
            7'h34:        d.op = OP_SRL;
            7'h39:        d.op = OP_SLL;
            7'h3C:        d.op = OP_SRA;
            7'h0F:        d.op = OP_CMPGE;
            default:      d.bad = 1'b1;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bmu_operand.sv
module bmu_operand #(
    parameter int LANES = bmu_pkg::LANES,
    parameter int LITW  = 8,
    localparam int DW   = LANES * 8
) (
    input  logic            lit_en,
    input  logic [LITW-1:0] lit,
    input  logic [DW-1:0]   b_reg,
    output logic [DW-1:0]   b_eff
);
    always_comb begin
        if (lit_en) b_eff = {{(DW-LITW){1'b0}}, lit};
        else        b_eff = b_reg;
    end
endmodule

// File: rtl/bmu_bytefield.sv
module bmu_bytefield
    import bmu_pkg::*;
#(
    parameter int LANES = bmu_pkg::LANES,
    localparam int DW   = LANES * 8,
    localparam int OFFW = $clog2(LANES),
    localparam int CW   = OFFW + 2
) (
    input  dec_t             dec,
    input  logic [DW-1:0]    a,
    input  logic [LANES-1:0] b_low,
    output logic [DW-1:0]    res
);
    logic [OFFW-1:0] off;
    logic [CW-1:0]   off_c;
    logic [CW-1:0]   nbytes;
    logic [CW-1:0]   fld_end;
    logic [OFFW+2:0] bitoff;
    logic [DW-1:0]   field_bits;
    logic [DW-1:0]   ext_bits;
    logic [DW-1:0]   keep_bits;

    assign off     = b_low[OFFW-1:0];
    assign off_c   = CW'(off);
    assign nbytes  = CW'(1) << dec.size;
    assign fld_end = off_c + nbytes;
    assign bitoff  = {off, 3'b000};

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [CW-1:0] KI = CW'(k);
        logic in_fld, in_ext, keep;
        assign in_fld = (KI >= off_c) && (KI < fld_end);
        assign in_ext = (KI < nbytes);
        assign keep   = (dec.op == OP_ZAP) ? ~b_low[k] : b_low[k];
        assign field_bits[k*8 +: 8] = {8{in_fld}};
        assign ext_bits[k*8 +: 8]   = {8{in_ext}};
        assign keep_bits[k*8 +: 8]  = {8{keep}};
    end

    always_comb begin
        unique case (dec.op)
            OP_MSK:            res = a & ~field_bits;
            OP_EXT:            res = (a >> bitoff) & ext_bits;
            OP_INS:            res = (a << bitoff) & field_bits;
            OP_ZAP, OP_ZAPNOT: res = a & keep_bits;
            default:           res = '0;
        endcase
    end
endmodule

// File: rtl/bmu_shiftcmp.sv
module bmu_shiftcmp
    import bmu_pkg::*;
#(
    parameter int LANES = bmu_pkg::LANES,
    localparam int DW   = LANES * 8,
    localparam int SHW  = $clog2(DW)
) (
    input  dec_t          dec,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res
);
    logic [SHW-1:0]   amt;
    logic [LANES-1:0] ge;

    assign amt = b[SHW-1:0];

    for (genvar k = 0; k < LANES; k++) begin : g_cmp
        assign ge[k] = (a[k*8 +: 8] >= b[k*8 +: 8]);
    end

    always_comb begin
        unique case (dec.op)
            OP_SRL:   res = a >> amt;
            OP_SLL:   res = a << amt;
            OP_SRA:   res = DW'($signed(a) >>> amt);
            OP_CMPGE: res = {{(DW-LANES){1'b0}}, ge};
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/bmu_top.sv
module bmu_top
    import bmu_pkg::*;
#(
    parameter int LANES = bmu_pkg::LANES,
    localparam int DW   = LANES * 8,
    localparam int SHW  = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [20:5]   insn,
    input  logic [DW-1:0] a_val,
    input  logic [DW-1:0] b_val,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          illegal
);
    dec_t          dec;
    logic [DW-1:0] b_eff;
    logic [DW-1:0] bf_res;
    logic [DW-1:0] sc_res;
    logic [DW-1:0] nxt_res;

    assign dec = decode(insn[11:5]);

    bmu_operand #(.LANES(LANES), .LITW(8)) u_opnd (
        .lit_en (insn[12]),
        .lit    (insn[20:13]),
        .b_reg  (b_val),
        .b_eff  (b_eff)
    );

    bmu_bytefield #(.LANES(LANES)) u_bfld (
        .dec   (dec),
        .a     (a_val),
        .b_low (b_eff[LANES-1:0]),
        .res   (bf_res)
    );

    bmu_shiftcmp #(.LANES(LANES)) u_shcmp (
        .dec (dec),
        .a   (a_val),
        .b   (b_eff),
        .res (sc_res)
    );

    always_comb begin
        unique case (dec.op)
            OP_MSK, OP_EXT, OP_INS, OP_ZAP, OP_ZAPNOT: nxt_res = bf_res;
            OP_SRL, OP_SLL, OP_SRA, OP_CMPGE:          nxt_res = sc_res;
            default:                                   nxt_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= dec.bad ? '0 : nxt_res;
                illegal <= dec.bad;
            end
        end
    end

    // R10: one output pulse per accepted request
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r10_hold_result: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(illegal)));
    // R9: flagged operations return zero
    a_r9_illegal_zero: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (result == '0));
    // R8: compare mask never reaches the upper bits
    a_r8_cmp_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && insn[11:5] == 7'h0F) |=> (result[DW-1:LANES] == '0 && !illegal));
    // R6: a zero shift amount passes A through a left shift
    a_r6_sll_zero_amt: assert property (@(posedge clk) disable iff (rst)
        (in_valid && insn[11:5] == 7'h39 && b_eff[SHW-1:0] == '0)
        |=> (result == $past(a_val)));
endmodule

// File: tb/tb_bmu_top.sv
module tb_bmu_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [20:5] insn;
    logic [63:0] a_val, b_val;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal;

    int n_checks = 0;
    int n_fail   = 0;

    bmu_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .a_val(a_val), .b_val(b_val),
        .out_valid(out_valid), .result(result), .illegal(illegal)
    );

    always #5 clk = ~clk;

    localparam logic [63:0] PAT = 64'h8877_6655_4433_2211;

    // Reference from the requirement text: returns {illegal, result}.
    function automatic logic [64:0] model(input logic [6:0] f, input logic [63:0] a,
                                          input logic [63:0] b);
        logic [63:0] r = '0;
        int o = int'(b[2:0]);
        int n = 1 << f[5:4];
        int s = int'(b[5:0]);
        if (f[6] == 1'b0 && f[3:0] == 4'h2) begin
            r = a;
            for (int k = 0; k < 8; k++) if (k >= o && k < o + n) r[k*8 +: 8] = 8'h00;
        end else if (f[6] == 1'b0 && f[3:0] == 4'h6) begin
            for (int k = 0; k < 8; k++) if (k < n && k + o < 8) r[k*8 +: 8] = a[(k+o)*8 +: 8];
        end else if (f[6] == 1'b0 && f[3:0] == 4'hB) begin
            for (int k = 0; k < 8; k++) if (k >= o && k < o + n) r[k*8 +: 8] = a[(k-o)*8 +: 8];
        end else if (f == 7'h30 || f == 7'h31) begin
            for (int k = 0; k < 8; k++)
                r[k*8 +: 8] = ((b[k] == 1'b1) == (f == 7'h30)) ? 8'h00 : a[k*8 +: 8];
        end else if (f == 7'h34) begin
            for (int i = 0; i < 64; i++) r[i] = (i + s < 64) ? a[i+s] : 1'b0;
        end else if (f == 7'h39) begin
            for (int i = 0; i < 64; i++) r[i] = (i >= s) ? a[i-s] : 1'b0;
        end else if (f == 7'h3C) begin
            for (int i = 0; i < 64; i++) r[i] = (i + s < 64) ? a[i+s] : a[63];
        end else if (f == 7'h0F) begin
            for (int k = 0; k < 8; k++) r[k] = (a[k*8 +: 8] >= b[k*8 +: 8]);
        end else begin
            return {1'b1, 64'h0};
        end
        return {1'b0, r};
    endfunction

    task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request, then compare registered outputs after the edge.
    task automatic run_op(input string req, input logic [6:0] f, input logic lit_en,
                          input logic [7:0] lit, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] b_used = lit_en ? {56'h0, lit} : b;
        @(negedge clk);
        in_valid = 1'b1;
        insn     = {lit, lit_en, f};
        a_val    = a;
        b_val    = b;
        @(posedge clk);
        #1;
        check(req, {illegal, result}, model(f, a, b_used));
        check(req, {64'h0, out_valid}, 65'h1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; insn = '0; a_val = '0; b_val = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset", {illegal, result}, 65'h0);
        check("R10 reset valid", {64'h0, out_valid}, 65'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_fields();
        int offs[4] = '{0, 3, 5, 7};
        for (int sz = 0; sz < 4; sz++)
            for (int oi = 0; oi < 4; oi++) begin
                run_op("R2 mask",    7'(8'h02 + 8'(sz*16)), 1'b0, 8'h0, PAT, 64'hFFFF_FFF0 | 64'(offs[oi]));
                run_op("R3 extract", 7'(8'h06 + 8'(sz*16)), 1'b0, 8'h0, PAT, 64'(offs[oi]));
                run_op("R4 insert",  7'(8'h0B + 8'(sz*16)), 1'b0, 8'h0, PAT, 64'hA0 | 64'(offs[oi]));
            end
    endtask

    task automatic t_zap();
        run_op("R5 zap",    7'h30, 1'b0, 8'h0, PAT, 64'hFFFF_0000_0000_00A5);
        run_op("R5 zapnot", 7'h31, 1'b0, 8'h0, PAT, 64'h0000_0000_0000_003C);
        run_op("R5 zap all", 7'h30, 1'b0, 8'h0, PAT, 64'hFF);
    endtask

    task automatic t_shift();
        run_op("R6 srl", 7'h34, 1'b0, 8'h0, PAT, 64'hFFFF_FFFF_FFFF_FFC5);
        run_op("R6 sll", 7'h39, 1'b0, 8'h0, PAT, 64'h0000_0100_0000_0047);
        run_op("R6 sll zero", 7'h39, 1'b0, 8'h0, PAT, 64'hFFC0);
        run_op("R7 sra neg", 7'h3C, 1'b0, 8'h0, PAT, 64'hFF00_0000_0000_0044);
        run_op("R7 sra pos", 7'h3C, 1'b0, 8'h0, 64'h7123_4567_89AB_CDEF, 64'h0C);
        run_op("R7 sra max", 7'h3C, 1'b0, 8'h0, PAT, 64'h3F);
    endtask

    task automatic t_cmp();
        run_op("R8 cmp", 7'h0F, 1'b0, 8'h0, 64'h00FF_8080_1234_7F01, 64'h01FE_8081_1234_8000);
        run_op("R8 cmp equal", 7'h0F, 1'b0, 8'h0, PAT, PAT);
    endtask

    task automatic t_literal();
        run_op("R1 literal zapnot", 7'h31, 1'b1, 8'h0F, PAT, 64'hFFFF_FFFF_FFFF_FFF0);
        run_op("R1 literal extract", 7'h16, 1'b1, 8'h02, PAT, 64'h5);
        run_op("R1 register b", 7'h31, 1'b0, 8'h0F, PAT, 64'hF0);
    endtask

    task automatic t_illegal();
        run_op("R9 illegal 0x00", 7'h00, 1'b0, 8'h0, PAT, 64'h1);
        run_op("R9 illegal 0x7F", 7'h7F, 1'b1, 8'hFF, PAT, 64'h1);
        run_op("R9 illegal 0x42", 7'h42, 1'b0, 8'h0, PAT, 64'h0);
    endtask

    task automatic t_hold();
        run_op("R10 before hold", 7'h06, 1'b0, 8'h0, PAT, 64'h1);
        @(negedge clk);
        insn = {8'h0, 1'b0, 7'h30}; a_val = 64'hDEAD; b_val = 64'hFF;
        @(posedge clk);
        #1;
        check("R10 hold", {illegal, result}, {1'b0, 64'h22});
        check("R10 hold valid", {64'h0, out_valid}, 65'h0);
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_fields();
        t_zap();
        t_shift();
        t_cmp();
        t_literal();
        t_illegal();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule